// File: doc/BRIEF.md
# Indirect Configuration Register Bridge

This block lets a host reach a bank of internal configuration words through four directly addressed host registers: a data word, a control word, a ready-status word and a completion-status word. The host never addresses the internal words directly. It names one of them with an address code inside the control word. A write-select bit in the same word picks the direction of the transfer.

To write an internal word, the host places the value in the data register and then writes the control word with the write-select bit set. To read one, it writes the control word with that bit clear. In both cases it polls the ready bit until the access has finished. After a read, the data register holds the selected word. Each access takes a fixed number of cycles. Each completion sets a sticky status flag, which the host clears by writing a one to it.

The internal bank is part of the block. It holds seven general configuration words, a two-word station address and a filter-mode word.

Top module: `cfg_ibridge`

## Requirements
- R1: After reset the ready register reads 0x0001_0000, the data and completion-status registers read 0, and every internal word reads back as 0.
- R2: Host register offsets on `bus_addr` are 0 for data, 1 for control, 2 for ready status and 3 for completion status. Reading the control offset returns the last control word that was accepted.
- R3: A control write with bit 15 set and an address code in bits 9:0 copies the value held in the data register into the selected internal word. A later read of that word returns the value.
- R4: A control write with bit 15 clear loads the data register with the selected internal word by the time ready returns.
- R5: Ready is bit 16 of the ready register, and every other bit of that register reads 0. The bit reads 0 for exactly 4 clock cycles after the clock edge that accepts a control write, and reads 1 again after the fourth edge that follows.
- R6: A control write that arrives while ready is 0 is ignored. The access already in progress completes with its own code and direction, and its timing does not change.
- R7: The valid codes are 0x200, 0x240, 0x280, 0x2C0, 0x300, 0x320, 0x340, 0x380 (station address low), 0x384 (station address high) and 0x390 (filter mode). A read of any other code returns 0, and a write to any other code changes no internal word.
- R8: The station address high word keeps only bits 15:0, so a read of it returns 0 in bits 31:16. The low word keeps all 32 bits.
- R9: Bit 0 of the completion-status register, and the `done_irq` output, become 1 when any access completes. They stay 1 until the host writes a 1 to bit 0. Writing a 0 leaves them unchanged.
- R10: A write access uses the data value present when its control word was accepted. Changing the data register during the access does not alter the value stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr_en | input | 1 | Host write strobe, one cycle per write |
| bus_addr | input | 2 | Host register offset |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data for `bus_addr` (combinational) |
| done_irq | output | 1 | Sticky access-complete flag |

## Verification
A table writes a distinct pattern to every valid code, and to two unused codes, then reads each one back. The patterns include all ones, all zeros, a single top bit and mixed words. This shows that each code decodes to its own storage, that the station high word truncates, and that unused codes read 0. A later re-read of the first code shows that the writes to unused codes clobbered nothing.

Directed sequences then do the following:
- count the cycles during which ready stays low;
- issue a second control word in the middle of a read, to show that the first access alone completes and that its timing is unchanged;
- change the data register in the middle of a write;
- exercise the write-one-to-clear behaviour of the completion flag with both a zero and a one.

// File: rtl/cfg_ibridge_pkg.sv
package cfg_ibridge_pkg;

   localparam int NUM_REGS   = 10;
   localparam int CODE_W     = 10;
   localparam int STA_HI_IDX = 8;

   // Address codes of the internal bank, one per stored word.
   localparam logic [CODE_W-1:0] REG_CODE [NUM_REGS] = '{
      10'h200, 10'h240, 10'h280, 10'h2C0, 10'h300,
      10'h320, 10'h340, 10'h380, 10'h384, 10'h390
   };

   typedef enum logic [1:0] {
      HA_DATA  = 2'd0,
      HA_CTRL  = 2'd1,
      HA_READY = 2'd2,
      HA_IRQ   = 2'd3
   } host_reg_e;

endpackage

// File: rtl/cfg_bank.sv
module cfg_bank
   import cfg_ibridge_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int STA_HI_BITS = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CODE_W-1:0] code,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   logic [NUM_REGS-1:0] hit;
   logic [DATA_W-1:0]   regq [NUM_REGS];

   if (STA_HI_BITS < 1 || STA_HI_BITS >= DATA_W) begin : g_bad_hi
      $error("cfg_bank: STA_HI_BITS out of range");
   end

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
      assign hit[i] = (code == REG_CODE[i]);
      if (i == STA_HI_IDX) begin : g_narrow
         logic [STA_HI_BITS-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                q <= '0;
            else if (wr_en && hit[i])  q <= wdata[STA_HI_BITS-1:0];
         end
         assign regq[i] = {{(DATA_W-STA_HI_BITS){1'b0}}, q};
      end else begin : g_full
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                q <= '0;
            else if (wr_en && hit[i])  q <= wdata;
         end
         assign regq[i] = q;
      end
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (hit[i]) rdata = rdata | regq[i];
      end
   end

endmodule

// File: rtl/cfg_access_seq.sv
module cfg_access_seq #(
   parameter int LATENCY = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic fire
);

   localparam int CNT_W = (LATENCY < 2) ? 1 : $clog2(LATENCY);

   logic [CNT_W-1:0] cnt;

   if (LATENCY < 1) begin : g_bad_lat
      $error("cfg_access_seq: LATENCY must be at least 1");
   end

   assign fire = busy && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (start && !busy) begin
         busy <= 1'b1;
         cnt  <= CNT_W'(LATENCY - 1);
      end else if (fire) begin
         busy <= 1'b0;
      end else if (busy) begin
         cnt  <= cnt - 1'b1;
      end
   end

endmodule

// File: rtl/cfg_ibridge.sv
module cfg_ibridge
   import cfg_ibridge_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int HOST_AW     = 2,
   parameter int LATENCY     = 4,
   parameter int WE_BIT      = 15,
   parameter int RDY_BIT     = 16,
   parameter int STA_HI_BITS = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr_en,
   input  logic [HOST_AW-1:0] bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic               done_irq
);

   if (HOST_AW != 2)                   begin : g_bad_aw  $error("cfg_ibridge: HOST_AW must be 2"); end
   if (WE_BIT < CODE_W || WE_BIT >= DATA_W) begin : g_bad_we  $error("cfg_ibridge: WE_BIT out of range"); end
   if (RDY_BIT >= DATA_W)              begin : g_bad_rdy $error("cfg_ibridge: RDY_BIT out of range"); end

   localparam logic [DATA_W-1:0] RDY_MASK = DATA_W'(1) << RDY_BIT;

   host_reg_e         hsel;
   logic              wr_data, wr_ctrl, wr_irq;
   logic              acc_start, seq_busy, seq_fire;
   logic [DATA_W-1:0] data_lo_q, ctrl_q, pend_data, bank_rdata;
   logic [CODE_W-1:0] pend_code;
   logic              pend_we, irq_q;

   assign hsel      = host_reg_e'(bus_addr);
   assign wr_data   = bus_wr_en && (hsel == HA_DATA);
   assign wr_ctrl   = bus_wr_en && (hsel == HA_CTRL);
   assign wr_irq    = bus_wr_en && (hsel == HA_IRQ);
   assign acc_start = wr_ctrl && !seq_busy;

   cfg_access_seq #(.LATENCY(LATENCY)) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .start (acc_start),
      .busy  (seq_busy),
      .fire  (seq_fire)
   );

   cfg_bank #(.DATA_W(DATA_W), .STA_HI_BITS(STA_HI_BITS)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (seq_fire && pend_we),
      .code  (pend_code),
      .wdata (pend_data),
      .rdata (bank_rdata)
   );

   // Request capture: only an accepted control word updates these.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q    <= '0;
         pend_we   <= 1'b0;
         pend_code <= '0;
         pend_data <= '0;
      end else if (acc_start) begin
         ctrl_q    <= bus_wdata;
         pend_we   <= bus_wdata[WE_BIT];
         pend_code <= bus_wdata[CODE_W-1:0];
         pend_data <= data_lo_q;
      end
   end

   // Data word: read completion takes priority over a host write.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    data_lo_q <= '0;
      else if (seq_fire && !pend_we) data_lo_q <= bank_rdata;
      else if (wr_data)              data_lo_q <= bus_wdata;
   end

   // Completion flag: set wins over write-one-to-clear.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      irq_q <= 1'b0;
      else if (seq_fire)               irq_q <= 1'b1;
      else if (wr_irq && bus_wdata[0]) irq_q <= 1'b0;
   end

   always_comb begin
      unique case (hsel)
         HA_DATA:  bus_rdata = data_lo_q;
         HA_CTRL:  bus_rdata = ctrl_q;
         HA_READY: bus_rdata = seq_busy ? '0 : RDY_MASK;
         HA_IRQ:   bus_rdata = {{(DATA_W-1){1'b0}}, irq_q};
         default:  bus_rdata = '0;
      endcase
   end

   assign done_irq = irq_q;

endmodule

// File: rtl/cfg_ibridge_chk.sv
module cfg_ibridge_chk
   import cfg_ibridge_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int LATENCY     = 4,
   parameter int STA_HI_BITS = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              fire,
   input logic              pend_we,
   input logic [CODE_W-1:0] pend_code,
   input logic [DATA_W-1:0] pend_data,
   input logic [DATA_W-1:0] data_lo,
   input logic              irq_q
);

   localparam int LC_W = $clog2(LATENCY + 2);

   logic [LC_W-1:0] lat_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                lat_cnt <= '0;
      else if (start && !busy)   lat_cnt <= LC_W'(1);
      else if (busy && !fire)    lat_cnt <= lat_cnt + 1'b1;
   end

   AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> (lat_cnt == LC_W'(LATENCY)));                               // R5

   AST_REQ_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(pend_code) && $stable(pend_we)));                  // R6

   AST_WDATA_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(pend_data));                                        // R10

   AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> irq_q);                                                     // R9

   AST_STA_HI_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !pend_we && pend_code == REG_CODE[STA_HI_IDX])
      |=> (data_lo[DATA_W-1:STA_HI_BITS] == '0));                          // R8

endmodule

bind cfg_ibridge cfg_ibridge_chk #(
   .DATA_W(DATA_W), .LATENCY(LATENCY), .STA_HI_BITS(STA_HI_BITS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (acc_start),
   .busy      (seq_busy),
   .fire      (seq_fire),
   .pend_we   (pend_we),
   .pend_code (pend_code),
   .pend_data (pend_data),
   .data_lo   (data_lo_q),
   .irq_q     (irq_q)
);

// File: tb/cfg_ibridge_tb.sv
`timescale 1ns/1ps
module cfg_ibridge_tb;

   localparam logic [1:0]  A_DATA = 2'd0, A_CTRL = 2'd1, A_RDY = 2'd2, A_IRQ = 2'd3;
   localparam logic [31:0] WR     = 32'h0000_8000;
   localparam logic [31:0] RDYV   = 32'h0001_0000;
   localparam int          NV     = 12;

   // {code[9:0], write value, expected read-back}
   localparam logic [73:0] VEC [NV] = '{
      {10'h200, 32'hAAAA_5555, 32'hAAAA_5555},
      {10'h240, 32'h1234_5678, 32'h1234_5678},
      {10'h280, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
      {10'h2C0, 32'h0000_0000, 32'h0000_0000},
      {10'h300, 32'h8000_0001, 32'h8000_0001},
      {10'h320, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
      {10'h340, 32'h0000_001D, 32'h0000_001D},
      {10'h380, 32'h0403_0201, 32'h0403_0201},
      {10'h384, 32'hCAFE_0605, 32'h0000_0605},
      {10'h390, 32'h8000_0000, 32'h8000_0000},
      {10'h3A0, 32'h1111_1111, 32'h0000_0000},
      {10'h000, 32'h2222_2222, 32'h0000_0000}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr_en = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        done_irq;

   int n_checks = 0;
   int n_fail   = 0;

   always #2.5 clk = ~clk;

   cfg_ibridge u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr_en (bus_wr_en),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .done_irq  (done_irq)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %08h expected %08h", req, got, exp);
      end
   endtask

   task automatic host_write(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr_en = 1'b0;
   endtask

   task automatic peek(input logic [1:0] a, output logic [31:0] v);
      bus_addr = a;
      #1 v = bus_rdata;
   endtask

   task automatic wait_ready();
      logic [31:0] v;
      peek(A_RDY, v);
      while (v[16] !== 1'b1) begin
         @(negedge clk);
         peek(A_RDY, v);
      end
   endtask

   task automatic cfg_wr(input logic [9:0] code, input logic [31:0] d);
      host_write(A_DATA, d);
      host_write(A_CTRL, WR | {22'd0, code});
      wait_ready();
   endtask

   task automatic cfg_rd(input logic [9:0] code, output logic [31:0] v);
      host_write(A_CTRL, {22'd0, code});
      wait_ready();
      peek(A_DATA, v);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      peek(A_RDY, v);  check("R1 ready reset", v, RDYV);
      peek(A_DATA, v); check("R1 data reset", v, 32'h0);
      peek(A_IRQ, v);  check("R1 status reset", v, 32'h0);
      check("R1 done_irq reset", {31'd0, done_irq}, 32'h0);
      cfg_rd(10'h380, v); check("R1 bank reset", v, 32'h0);

      // R3/R4/R7/R8: table walk, write then read back
      for (int i = 0; i < NV; i++) begin
         logic [9:0]  c;
         logic [31:0] w, e;
         {c, w, e} = VEC[i];
         cfg_wr(c, w);
         cfg_rd(c, v);
         check($sformatf("R3 R4 R7 R8 code %03h", c), v, e);
      end
      cfg_rd(10'h200, v); check("R7 unknown write left 0x200 intact", v, 32'hAAAA_5555);

      // R2: control word read-back
      peek(A_CTRL, v); check("R2 control read-back", v, 32'h0000_0200);

      // R5: ready low for exactly four cycles
      host_write(A_CTRL, 32'h0000_0240);
      peek(A_RDY, v); check("R5 ready low k1", v, 32'h0);
      for (int k = 2; k <= 4; k++) begin
         @(negedge clk); peek(A_RDY, v);
         check($sformatf("R5 ready low k%0d", k), v, 32'h0);
      end
      @(negedge clk); peek(A_RDY, v); check("R5 ready back", v, RDYV);
      peek(A_DATA, v); check("R4 read 0x240", v, 32'h1234_5678);

      // R6: control write while busy is ignored, timing unchanged
      host_write(A_DATA, 32'h5A5A_0F0F);
      host_write(A_CTRL, 32'h0000_0280);
      host_write(A_CTRL, WR | 32'h0000_0200);
      peek(A_RDY, v); check("R6 busy after ignored write", v, 32'h0);
      @(negedge clk); peek(A_RDY, v); check("R6 still busy", v, 32'h0);
      @(negedge clk); peek(A_RDY, v); check("R6 ready on time", v, RDYV);
      peek(A_DATA, v); check("R6 first access served", v, 32'hFFFF_FFFF);
      peek(A_CTRL, v); check("R6 control unchanged", v, 32'h0000_0280);
      cfg_rd(10'h200, v); check("R6 ignored write had no effect", v, 32'hAAAA_5555);

      // R10: data change during write access
      host_write(A_DATA, 32'h1357_9BDF);
      host_write(A_CTRL, WR | 32'h0000_0390);
      host_write(A_DATA, 32'h0BAD_0BAD);
      wait_ready();
      cfg_rd(10'h390, v); check("R10 captured data stored", v, 32'h1357_9BDF);

      // R9: sticky completion flag, write-one-to-clear
      peek(A_IRQ, v); check("R9 flag set", v, 32'h1);
      host_write(A_IRQ, 32'h0);
      peek(A_IRQ, v); check("R9 write 0 keeps flag", v, 32'h1);
      check("R9 done_irq kept", {31'd0, done_irq}, 32'h1);
      host_write(A_IRQ, 32'h1);
      peek(A_IRQ, v); check("R9 write 1 clears", v, 32'h0);
      check("R9 done_irq cleared", {31'd0, done_irq}, 32'h0);
      cfg_rd(10'h384, v); check("R8 high word narrow", v, 32'h0000_0605);
      check("R9 done_irq after read", {31'd0, done_irq}, 32'h1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule